// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block sits between a processor load/store port and a slower memory that is addressed by 32-bit words. It holds 2^LINES_LOG2 lines of 2^WORDS_LOG2 words each. Every 32-bit byte address is split into a tag, a line index, a word offset and a byte offset. A line hits when its valid flag is set and its stored tag matches the address tag. A read hit completes in the cycle of the lookup.

A read miss holds the processor. The controller fetches the whole line from memory, starting at the line-aligned word, one word per handshake. It then writes the tag and sets the valid flag. The held request is not answered from the fill data. Instead the lookup runs again, and it now hits. Every store goes to memory at once as a single word write. On a hit the cached word is also updated. A store that misses leaves the cache untouched and finishes when memory accepts the write.

The processor keeps `cpu_req` and its address and data steady until `cpu_ready` pulses. The memory side moves one word on every cycle in which `mem_valid` and `mem_ready` are both high. Read data comes with `mem_ready`.

Top module: `dmwt_cache`

## Requirements
- R1: The byte address is decoded as follows. The line index is bits [LINES_LOG2+WORDS_LOG2+1 : WORDS_LOG2+2]. The word offset is bits [WORDS_LOG2+1 : 2]. The tag is every bit above the index, which gives 32-LINES_LOG2-WORDS_LOG2-2 bits. Bits [1:0] select a byte and do not change which word a read returns.
- R2: Reset clears every valid flag, so the first read of any line after reset misses. During reset and just after it, `cpu_ready`, `stall` and `mem_valid` are low.
- R3: A read that hits raises `cpu_ready` in the same cycle as the lookup, with the addressed word on `cpu_rdata`. It causes no memory transfer.
- R4: A read miss issues exactly 2^WORDS_LOG2 memory reads (`mem_we` low). Their word addresses are consecutive and start at the line-aligned word address {tag,index,0}. While `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_we` stay stable.
- R5: After the last fill word, the line holds the new tag and is valid. The held read is looked up again and returns the requested word. A later read of another tag with the same index misses and replaces the line.
- R6: `stall` is high whenever a request is pending without `cpu_ready`, from miss detection until the replayed lookup answers. `stall` is low in any cycle where `cpu_ready` is high.
- R7: Each store makes exactly one memory write, with word address `cpu_addr[31:2]` and data `cpu_wdata`. `cpu_ready` pulses in the cycle memory accepts the write. If the store hits, later reads of that word return the stored value without a fill.
- R8: A store that misses does not allocate. The line at its index keeps its previous tag and contents, so a later read of the old address still hits.
- R9: With `cpu_req` low, no memory transfer starts and `cpu_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` on a load |
| cpu_ready | output | 1 | Request completes this cycle |
| stall | output | 1 | Request pending and not yet complete |
| mem_valid | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = memory write, 0 = line-fill read |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completes the current transfer |

## Verification
The hardest case to reach is a store that misses on an index whose line already holds valid data under another tag. Reaching it proves that the store neither allocates nor evicts. The stimulus table first loads the line with a read of one tag. It then stores to the other tag at the same index, reads the first address again (it must still hit), and then reads the stored address (it must miss and return the written value). Memory latency in the bench changes from one transfer to the next. Fill bursts therefore see both back-to-back and delayed handshakes, and each burst's word addresses and count are checked against the line-aligned base.

// File: rtl/dmwt_pkg.sv
package dmwt_pkg;
   typedef enum logic [1:0] {
      ST_LOOKUP = 2'd0,
      ST_FILL   = 2'd1,
      ST_STORE  = 2'd2
   } dmwt_state_e;

   function automatic int unsigned dmwt_tag_width(input int unsigned lines_log2,
                                                   input int unsigned words_log2);
      return 32 - lines_log2 - words_log2 - 2;
   endfunction
endpackage

// File: rtl/dmwt_addr_split.sv
module dmwt_addr_split #(
   parameter int unsigned LINES_LOG2 = 3,
   parameter int unsigned WORDS_LOG2 = 1,
   localparam int unsigned TAG_W  = dmwt_pkg::dmwt_tag_width(LINES_LOG2, WORDS_LOG2),
   localparam int unsigned WOFF_W = (WORDS_LOG2 > 0) ? WORDS_LOG2 : 1
) (
   input  logic [31:0]           addr,
   output logic [TAG_W-1:0]      tag,
   output logic [LINES_LOG2-1:0] idx,
   output logic [WOFF_W-1:0]     woff
);
   localparam int unsigned IDX_LO = WORDS_LOG2 + 2;
   localparam int unsigned TAG_LO = IDX_LO + LINES_LOG2;

   assign tag = addr[31:TAG_LO];
   assign idx = addr[TAG_LO-1:IDX_LO];

   generate
      if (WORDS_LOG2 == 0) begin : g_single_word
         assign woff = '0;
      end else begin : g_multi_word
         assign woff = addr[IDX_LO-1:2];
      end
   endgenerate
endmodule

// File: rtl/dmwt_tag_store.sv
module dmwt_tag_store #(
   parameter int unsigned LINES_LOG2 = 3,
   parameter int unsigned TAG_W      = 26,
   localparam int unsigned LINES     = 1 << LINES_LOG2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [LINES_LOG2-1:0] look_idx,
   input  logic [TAG_W-1:0]      look_tag,
   output logic                  hit,
   input  logic                  wr_en,
   input  logic [LINES_LOG2-1:0] wr_idx,
   input  logic [TAG_W-1:0]      wr_tag
);
   logic [LINES-1:0] line_ok;
   logic [TAG_W-1:0] line_tag [LINES];

   generate
      for (genvar gi = 0; gi < LINES; gi++) begin : g_line
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               line_ok[gi]  <= 1'b0;
               line_tag[gi] <= '0;
            end else if (wr_en && (wr_idx == LINES_LOG2'(gi))) begin
               line_ok[gi]  <= 1'b1;
               line_tag[gi] <= wr_tag;
            end
         end
      end
   endgenerate

   assign hit = line_ok[look_idx] && (line_tag[look_idx] == look_tag);
endmodule

// File: rtl/dmwt_data_store.sv
module dmwt_data_store #(
   parameter int unsigned LINES_LOG2 = 3,
   parameter int unsigned WORDS_LOG2 = 1,
   localparam int unsigned LINES  = 1 << LINES_LOG2,
   localparam int unsigned WORDS  = 1 << WORDS_LOG2,
   localparam int unsigned WOFF_W = (WORDS_LOG2 > 0) ? WORDS_LOG2 : 1
) (
   input  logic                  clk,
   input  logic [LINES_LOG2-1:0] rd_idx,
   input  logic [WOFF_W-1:0]     rd_woff,
   output logic [31:0]           rd_data,
   input  logic                  wr_en,
   input  logic [LINES_LOG2-1:0] wr_idx,
   input  logic [WOFF_W-1:0]     wr_woff,
   input  logic [31:0]           wr_data
);
   logic [31:0] words_q [LINES][WORDS];

   generate
      for (genvar gl = 0; gl < LINES; gl++) begin : g_line
         for (genvar gw = 0; gw < WORDS; gw++) begin : g_word
            always_ff @(posedge clk) begin
               if (wr_en && (wr_idx == LINES_LOG2'(gl)) && (wr_woff == WOFF_W'(gw)))
                  words_q[gl][gw] <= wr_data;
            end
         end
      end
   endgenerate

   assign rd_data = words_q[rd_idx][rd_woff];
endmodule

// File: rtl/dmwt_ctrl.sv
module dmwt_ctrl
   import dmwt_pkg::*;
#(
   parameter int unsigned WORDS_LOG2 = 1,
   localparam int unsigned WOFF_W = (WORDS_LOG2 > 0) ? WORDS_LOG2 : 1,
   localparam int unsigned WORDS  = 1 << WORDS_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic              hit,
   input  logic              mem_ready,
   output dmwt_state_e       state,
   output logic              cpu_ready,
   output logic [WOFF_W-1:0] fill_cnt,
   output logic              fill_wr,
   output logic              fill_done,
   output logic              store_upd
);
   localparam logic [WOFF_W-1:0] LAST_WORD = WOFF_W'(WORDS - 1);

   dmwt_state_e       state_q, state_d;
   logic [WOFF_W-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d   = state_q;
      cnt_d     = cnt_q;
      cpu_ready = 1'b0;
      fill_wr   = 1'b0;
      fill_done = 1'b0;
      store_upd = 1'b0;
      unique case (state_q)
         ST_LOOKUP: begin
            if (cpu_req && cpu_we) begin
               state_d = ST_STORE;
            end else if (cpu_req && hit) begin
               cpu_ready = 1'b1;
            end else if (cpu_req) begin
               state_d = ST_FILL;
               cnt_d   = '0;
            end
         end
         ST_FILL: begin
            if (mem_ready) begin
               fill_wr = 1'b1;
               if (cnt_q == LAST_WORD) begin
                  fill_done = 1'b1;
                  state_d   = ST_LOOKUP;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
         end
         ST_STORE: begin
            if (mem_ready) begin
               cpu_ready = 1'b1;
               store_upd = hit;
               state_d   = ST_LOOKUP;
            end
         end
         default: state_d = ST_LOOKUP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_LOOKUP;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign state    = state_q;
   assign fill_cnt = cnt_q;
endmodule

// File: rtl/dmwt_cache.sv
module dmwt_cache
   import dmwt_pkg::*;
#(
   parameter int unsigned LINES_LOG2 = 3,
   parameter int unsigned WORDS_LOG2 = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cpu_req,
   input  logic        cpu_we,
   input  logic [31:0] cpu_addr,
   input  logic [31:0] cpu_wdata,
   output logic [31:0] cpu_rdata,
   output logic        cpu_ready,
   output logic        stall,
   output logic        mem_valid,
   output logic        mem_we,
   output logic [29:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic [31:0] mem_rdata,
   input  logic        mem_ready
);
   localparam int unsigned TAG_W  = dmwt_tag_width(LINES_LOG2, WORDS_LOG2);
   localparam int unsigned WOFF_W = (WORDS_LOG2 > 0) ? WORDS_LOG2 : 1;

   generate
      if (LINES_LOG2 < 1 || LINES_LOG2 + WORDS_LOG2 > 10) begin : g_bad_geometry
         $error("dmwt_cache: LINES_LOG2 must be >= 1 and LINES_LOG2+WORDS_LOG2 <= 10");
      end
   endgenerate

   logic [TAG_W-1:0]      a_tag;
   logic [LINES_LOG2-1:0] a_idx;
   logic [WOFF_W-1:0]     a_woff;
   logic                  hit;
   dmwt_state_e           state;
   logic [WOFF_W-1:0]     fill_cnt;
   logic                  fill_wr, fill_done, store_upd;
   logic                  d_wr_en;
   logic [WOFF_W-1:0]     d_wr_woff;
   logic [31:0]           d_wr_data;
   logic [29:0]           fill_addr;

   dmwt_addr_split #(.LINES_LOG2(LINES_LOG2), .WORDS_LOG2(WORDS_LOG2)) u_split (
      .addr (cpu_addr),
      .tag  (a_tag),
      .idx  (a_idx),
      .woff (a_woff)
   );

   dmwt_tag_store #(.LINES_LOG2(LINES_LOG2), .TAG_W(TAG_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .look_idx (a_idx),
      .look_tag (a_tag),
      .hit      (hit),
      .wr_en    (fill_done),
      .wr_idx   (a_idx),
      .wr_tag   (a_tag)
   );

   assign d_wr_en   = fill_wr | store_upd;
   assign d_wr_woff = fill_wr ? fill_cnt : a_woff;
   assign d_wr_data = fill_wr ? mem_rdata : cpu_wdata;

   dmwt_data_store #(.LINES_LOG2(LINES_LOG2), .WORDS_LOG2(WORDS_LOG2)) u_data (
      .clk     (clk),
      .rd_idx  (a_idx),
      .rd_woff (a_woff),
      .rd_data (cpu_rdata),
      .wr_en   (d_wr_en),
      .wr_idx  (a_idx),
      .wr_woff (d_wr_woff),
      .wr_data (d_wr_data)
   );

   dmwt_ctrl #(.WORDS_LOG2(WORDS_LOG2)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_req   (cpu_req),
      .cpu_we    (cpu_we),
      .hit       (hit),
      .mem_ready (mem_ready),
      .state     (state),
      .cpu_ready (cpu_ready),
      .fill_cnt  (fill_cnt),
      .fill_wr   (fill_wr),
      .fill_done (fill_done),
      .store_upd (store_upd)
   );

   generate
      if (WORDS_LOG2 == 0) begin : g_fill_one
         assign fill_addr = {a_tag, a_idx};
      end else begin : g_fill_many
         assign fill_addr = {a_tag, a_idx, fill_cnt};
      end
   endgenerate

   assign mem_valid = (state == ST_FILL) || (state == ST_STORE);
   assign mem_we    = (state == ST_STORE);
   assign mem_addr  = (state == ST_STORE) ? cpu_addr[31:2] : fill_addr;
   assign mem_wdata = cpu_wdata;
   assign stall     = cpu_req && !cpu_ready;
endmodule

// File: rtl/dmwt_cache_chk.sv
module dmwt_cache_chk #(
   parameter int unsigned WORDS_LOG2 = 1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cpu_req,
   input logic        cpu_we,
   input logic [31:0] cpu_addr,
   input logic [31:0] cpu_wdata,
   input logic        cpu_ready,
   input logic        stall,
   input logic        mem_valid,
   input logic        mem_we,
   input logic [29:0] mem_addr,
   input logic [31:0] mem_wdata,
   input logic        mem_ready
);
   localparam logic [29:0] WMASK = 30'((1 << WORDS_LOG2) - 1);

   AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_req); // R9
   AST_NO_STALL_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !stall); // R6
   AST_READ_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && !cpu_we) |-> !mem_valid); // R3
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we))); // R4
   AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_we && mem_ready && ((mem_addr & WMASK) != WMASK))
      |=> (mem_valid && !mem_we && (mem_addr == $past(mem_addr) + 30'd1))); // R4
   AST_STORE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_we) |-> (mem_addr == cpu_addr[31:2] && mem_wdata == cpu_wdata)); // R7
   AST_STORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && cpu_we) |-> (mem_valid && mem_we && mem_ready)); // R7
endmodule

bind dmwt_cache dmwt_cache_chk #(.WORDS_LOG2(WORDS_LOG2)) u_chk (.*);

// File: tb/dmwt_cache_test.sv
`timescale 1ns/1ps
module dmwt_cache_test;
   localparam int unsigned LINES_LOG2 = 3;
   localparam int unsigned WORDS_LOG2 = 1;
   localparam int unsigned WORDS      = 1 << WORDS_LOG2;
   localparam int unsigned NVEC       = 15;

   // entry: {store, expect_fill, byte address, store data}
   localparam logic [65:0] VEC [NVEC] = '{
      {1'b0, 1'b1, 32'h0000_0000, 32'h0},          // cold miss line 0
      {1'b0, 1'b0, 32'h0000_0004, 32'h0},          // same line, word 1
      {1'b0, 1'b0, 32'h0000_0002, 32'h0},          // byte offset ignored
      {1'b0, 1'b1, 32'h0000_0040, 32'h0},          // conflict, index 0
      {1'b0, 1'b1, 32'h0000_0000, 32'h0},          // conflict back
      {1'b1, 1'b0, 32'h0000_0004, 32'hDEAD_0001},  // store hit
      {1'b0, 1'b0, 32'h0000_0004, 32'h0},          // updated word hits
      {1'b1, 1'b0, 32'h0000_0108, 32'hBEEF_0002},  // store miss, empty line
      {1'b0, 1'b1, 32'h0000_0108, 32'h0},          // fill brings stored word
      {1'b0, 1'b0, 32'h0000_010C, 32'h0},
      {1'b0, 1'b1, 32'h0000_0038, 32'h0},          // index 7
      {1'b0, 1'b0, 32'h0000_003C, 32'h0},
      {1'b1, 1'b0, 32'h0000_0078, 32'h1234_5678},  // store miss, other tag on index 7
      {1'b0, 1'b0, 32'h0000_0038, 32'h0},          // old line still present
      {1'b0, 1'b1, 32'h0000_0078, 32'h0}           // now misses, memory holds store
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_ready, stall;
   logic        mem_valid, mem_we;
   logic [29:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ready = 1'b0;

   int errors = 0;
   int checks = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   int hits = 0;
   int misses = 0;
   logic [29:0] rlog [4096];
   logic [31:0] refmem [1024];

   always #4 clk = ~clk;

   dmwt_cache #(.LINES_LOG2(LINES_LOG2), .WORDS_LOG2(WORDS_LOG2)) uut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_ready(cpu_ready), .stall(stall), .mem_valid(mem_valid), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ready(mem_ready)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory model: decides mem_ready at falling edges, varying latency
   initial begin
      int lat = 0;
      int wt = 0;
      logic        l_we = 1'b0;
      logic [29:0] l_addr = '0;
      logic [31:0] l_data = '0;
      for (int i = 0; i < 1024; i++) refmem[i] = 32'h5A00_0000 + i * 32'h0001_0003;
      forever begin
         @(negedge clk);
         if (mem_ready) begin
            if (l_we) begin
               refmem[l_addr[9:0]] = l_data;
               wr_cnt++;
            end else begin
               rlog[rd_cnt[11:0]] = l_addr;
               rd_cnt++;
            end
            mem_ready = 1'b0;
         end else if (mem_valid && rst_n) begin
            if (wt >= lat) begin
               l_we = mem_we; l_addr = mem_addr; l_data = mem_wdata;
               mem_rdata = refmem[mem_addr[9:0]];
               mem_ready = 1'b1;
               wt = 0;
               lat = (lat + 1) % 3;
            end else begin
               wt++;
            end
         end
      end
   end

   task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                         input bit exp_fill);
      int rd0;
      int wr0;
      bit stall_ok;
      logic [31:0] exp_word;
      logic [29:0] base;
      logic [31:0] got;
      rd0 = rd_cnt;
      wr0 = wr_cnt;
      stall_ok = 1'b1;
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      #1;
      while (!cpu_ready) begin
         if (!stall) stall_ok = 1'b0;
         @(negedge clk); #1;
      end
      if (stall) stall_ok = 1'b0;
      got = cpu_rdata;
      exp_word = refmem[a[11:2]];
      @(negedge clk);
      cpu_req = 1'b0;
      #1;
      check(stall_ok, "R6 stall window", {31'b0, stall_ok}, 32'd1);
      if (we) begin
         check(wr_cnt - wr0 == 1, "R7 one memory write", wr_cnt - wr0, 1);
         check(refmem[a[11:2]] == wd, "R7 memory word written", refmem[a[11:2]], wd);
         check(rd_cnt == rd0, "R8 store miss no fill", rd_cnt - rd0, 0);
      end else begin
         check(got == exp_word, "R5 read data", got, exp_word);
         check(rd_cnt - rd0 == (exp_fill ? WORDS : 0), "R3 fill word count",
               rd_cnt - rd0, exp_fill ? WORDS : 0);
         if (exp_fill) begin
            misses++;
            base = {a[31:WORDS_LOG2 + 2], {WORDS_LOG2{1'b0}}};
            for (int k = 0; k < int'(WORDS); k++)
               check(rlog[(rd0 + k) % 4096] == base + 30'(k), "R4 fill address",
                     {2'b0, rlog[(rd0 + k) % 4096]}, {2'b0, base + 30'(k)});
         end else begin
            hits++;
         end
      end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R2: reset state
      check(!cpu_ready && !stall && !mem_valid, "R2 outputs in reset",
            {29'b0, cpu_ready, stall, mem_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check(!cpu_ready && !stall && !mem_valid, "R2 outputs after reset",
            {29'b0, cpu_ready, stall, mem_valid}, 0);

      // R9: idle, no traffic
      begin
         bit quiet = 1'b1;
         for (int c = 0; c < 20; c++) begin
            @(negedge clk); #1;
            if (mem_valid || cpu_ready) quiet = 1'b0;
         end
         check(quiet && rd_cnt == 0 && wr_cnt == 0, "R9 idle no traffic", rd_cnt + wr_cnt, 0);
      end

      // table walk (R1 R3 R4 R5 R6 R7 R8)
      for (int v = 0; v < int'(NVEC); v++) begin
         access(VEC[v][65], VEC[v][63:32], VEC[v][31:0], VEC[v][64]);
      end
      check(misses == 6, "R5 total read misses", misses, 6);
      check(hits == 6, "R3 total read hits", hits, 6);

      // R1: top byte of a word, same line
      access(1'b0, 32'h0000_007B, 32'h0, 1'b0);

      // R2: reset in mid-run clears valid flags
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk); #1;
      check(!mem_valid && !cpu_ready, "R2 second reset quiet", {31'b0, mem_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      access(1'b0, 32'h0000_0004, 32'h0, 1'b1);
      access(1'b0, 32'h0000_0078, 32'h0, 1'b1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule